// File: doc/BRIEF.md
# Bidirectional Host Word Handshake Controller

This block paces single-word transfers between a host processor and the logic around it over an 8-bit parallel path. A strobe starts a transfer. At that moment a direction bit is sampled. With the bit low, the host sends words to a serial teletype converter. With the bit high, a local data source sends words to the host. For each word the host raises a request. The controller answers by pulling an active-low ready flag low. The host then lowers its request to mark the word as taken, and the cycle repeats. No word count ends the transfer. It stays open until an external done pulse closes it and releases the host interface.

A second function watches a small group of operator pushbuttons. Each button is synchronized and debounced. While any button is held, an activity output is high. When a held button is released, a sample-indicator output goes high for a set number of clocks, which is meant to drive an audible alarm. All handshake inputs are taken to be synchronous to the block clock.

Top module: `hsk_xfer_ctrl`

## Requirements
- R1: After reset, ready_n is 1, busy is 0, tty_load is 0, btn_active is 0 and sample_ind is 0.
- R2: A start_stb seen while idle sets busy on the following clock and samples dir_sel (0 = host to teletype, 1 = local source to host). Later changes of dir_sel, and strobes seen while busy, have no effect on the transfer in progress.
- R3: In input mode (dir_sel 1), ready_n goes low on the clock after an edge at which busy, host_req is 1 and a word is held. While ready_n stays low, host_rdata shows that word and does not change.
- R4: In input mode, a local_valid pulse loads local_data only when no word is held. A local_valid pulse that arrives while a word is held is ignored, and the held word is kept.
- R5: An edge at which ready_n is low and host_req is sampled 0 returns ready_n to 1 after that edge. In input mode the held word is consumed, and ready_n stays high until a new word is loaded, even if host_req is high.
- R6: In output mode (dir_sel 0), ready_n goes low after an edge with host_req 1. At the edge where host_req is sampled 0, host_wdata is captured onto tty_data, and tty_load is 1 for exactly one cycle.
- R7: xfer_done ends the transfer on the next clock: busy goes to 0, ready_n to 1, and any held word is discarded. xfer_done takes priority over every other input.
- R8: A level on a btn_raw bit is accepted only after it has been stable for DEB_CYCLES clocks after synchronization. btn_active is the OR of the accepted levels, and a pulse shorter than DEB_CYCLES leaves btn_active unchanged.
- R9: The accepted release of any button drives sample_ind high for exactly IND_CYCLES consecutive clocks.
- R10: With RETRIGGER = 1, a release accepted while sample_ind is high restarts the count. sample_ind then stays high for IND_CYCLES clocks after the later release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_sel | input | 1 | Direction, sampled at strobe: 0 host to teletype, 1 local to host |
| start_stb | input | 1 | One-cycle transfer start strobe |
| host_req | input | 1 | Host control request, one per word |
| host_wdata | input | DW | Word from the host in output mode |
| ready_n | output | 1 | Active-low word-ready flag to the host |
| host_rdata | output | DW | Word presented to the host in input mode |
| local_valid | input | 1 | Local source offers a word |
| local_data | input | DW | Word from the local source |
| tty_data | output | DW | Word passed to the teletype converter |
| tty_load | output | 1 | One-cycle load pulse for tty_data |
| xfer_done | input | 1 | Terminates the transfer |
| busy | output | 1 | Transfer in progress |
| btn_raw | input | NB | Raw operator pushbuttons |
| btn_active | output | 1 | Any debounced button is held |
| sample_ind | output | 1 | Sample indicator after a button release |

## Verification
The hardest case to reach is a second release that lands while the indicator is still counting down. The first release's window has to overlap the second, yet each release only counts once it has passed the synchronizer and the debounce counter. The stimulus presses two buttons together and then releases them a fixed number of clocks apart. Both releases take the same path, so the distance between them is known. The total high time of sample_ind must then equal that distance plus IND_CYCLES. In input mode, the bench also offers a second word while the first is still held, then raises host_req again after the handoff with no word loaded, to show that ready_n stays high.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WAIT  = 2'd1,
      ST_READY = 2'd2
   } xfer_state_e;

   typedef enum logic {
      DIR_TO_TTY  = 1'b0,
      DIR_TO_HOST = 1'b1
   } xfer_dir_e;

endpackage

// File: rtl/hsk_btn_filter.sv
module hsk_btn_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int DEB_CYCLES  = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_in,
   output logic level_out,
   output logic release_p
);
   localparam int CW = (DEB_CYCLES > 2) ? $clog2(DEB_CYCLES) : 1;
   localparam logic [CW-1:0] CNT_LAST = CW'(DEB_CYCLES - 1);

   initial begin
      if (SYNC_STAGES < 2) $error("hsk_btn_filter: SYNC_STAGES must be >= 2");
      if (DEB_CYCLES < 2)  $error("hsk_btn_filter: DEB_CYCLES must be >= 2");
   end

   logic [SYNC_STAGES-1:0] sync_sh;
   logic                   synced;
   logic [CW-1:0]          deb_cnt;
   logic                   level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_sh <= '0;
      else        sync_sh <= {sync_sh[SYNC_STAGES-2:0], raw_in};
   end
   assign synced = sync_sh[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         deb_cnt   <= '0;
         level_q   <= 1'b0;
         release_p <= 1'b0;
      end else begin
         release_p <= 1'b0;
         if (synced == level_q) begin
            deb_cnt <= '0;
         end else if (deb_cnt == CNT_LAST) begin
            deb_cnt   <= '0;
            level_q   <= synced;
            release_p <= level_q & ~synced;
         end else begin
            deb_cnt <= deb_cnt + 1'b1;
         end
      end
   end

   assign level_out = level_q;
endmodule

// File: rtl/hsk_sample_stretch.sv
module hsk_sample_stretch #(
   parameter int NB         = 4,
   parameter int IND_CYCLES = 1000,
   parameter bit RETRIGGER  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NB-1:0] release_vec,
   output logic          ind_out
);
   localparam int IW = $clog2(IND_CYCLES + 1);
   localparam logic [IW-1:0] IND_LOAD = IW'(IND_CYCLES);

   initial begin
      if (IND_CYCLES < 1) $error("hsk_sample_stretch: IND_CYCLES must be >= 1");
      if (NB < 1)         $error("hsk_sample_stretch: NB must be >= 1");
   end

   logic          any_rel;
   logic [IW-1:0] ind_cnt;

   assign any_rel = |release_vec;

   generate
      if (RETRIGGER) begin : g_retrig
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              ind_cnt <= '0;
            else if (any_rel)        ind_cnt <= IND_LOAD;
            else if (ind_cnt != '0)  ind_cnt <= ind_cnt - 1'b1;
         end
      end else begin : g_oneshot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         ind_cnt <= '0;
            else if (ind_cnt == '0 && any_rel)  ind_cnt <= IND_LOAD;
            else if (ind_cnt != '0)             ind_cnt <= ind_cnt - 1'b1;
         end
      end
   endgenerate

   assign ind_out = (ind_cnt != '0);
endmodule

// File: rtl/hsk_xfer_seq.sv
module hsk_xfer_seq
   import hsk_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dir_sel,
   input  logic          start_stb,
   input  logic          host_req,
   input  logic [DW-1:0] host_wdata,
   input  logic          local_valid,
   input  logic [DW-1:0] local_data,
   input  logic          xfer_done,
   output logic          ready_n,
   output logic [DW-1:0] host_rdata,
   output logic [DW-1:0] tty_data,
   output logic          tty_load,
   output logic          busy
);
   initial begin
      if (DW < 1) $error("hsk_xfer_seq: DW must be >= 1");
   end

   xfer_state_e   state;
   xfer_dir_e     dir_q;
   logic          held;
   logic [DW-1:0] elem_q;
   logic          word_ok;

   // A word may be offered when output mode is active or a local word is held
   assign word_ok = (dir_q == DIR_TO_TTY) || held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         dir_q    <= DIR_TO_TTY;
         held     <= 1'b0;
         elem_q   <= '0;
         ready_n  <= 1'b1;
         tty_data <= '0;
         tty_load <= 1'b0;
      end else begin
         tty_load <= 1'b0;
         if (xfer_done) begin
            state   <= ST_IDLE;
            ready_n <= 1'b1;
            held    <= 1'b0;
         end else begin
            case (state)
               ST_IDLE: begin
                  if (start_stb) begin
                     state <= ST_WAIT;
                     dir_q <= xfer_dir_e'(dir_sel);
                     held  <= 1'b0;
                  end
               end
               ST_WAIT: begin
                  if (dir_q == DIR_TO_HOST && local_valid && !held) begin
                     elem_q <= local_data;
                     held   <= 1'b1;
                  end
                  if (host_req && word_ok) begin
                     ready_n <= 1'b0;
                     state   <= ST_READY;
                  end
               end
               ST_READY: begin
                  if (!host_req) begin
                     ready_n <= 1'b1;
                     state   <= ST_WAIT;
                     held    <= 1'b0;
                     if (dir_q == DIR_TO_TTY) begin
                        tty_data <= host_wdata;
                        tty_load <= 1'b1;
                     end
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign busy       = (state != ST_IDLE);
   assign host_rdata = elem_q;
endmodule

// File: rtl/hsk_xfer_ctrl.sv
module hsk_xfer_ctrl #(
   parameter int DW          = 8,
   parameter int NB          = 4,
   parameter int SYNC_STAGES = 2,
   parameter int DEB_CYCLES  = 16,
   parameter int IND_CYCLES  = 1000,
   parameter bit RETRIGGER   = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dir_sel,
   input  logic          start_stb,
   input  logic          host_req,
   input  logic [DW-1:0] host_wdata,
   output logic          ready_n,
   output logic [DW-1:0] host_rdata,
   input  logic          local_valid,
   input  logic [DW-1:0] local_data,
   output logic [DW-1:0] tty_data,
   output logic          tty_load,
   input  logic          xfer_done,
   output logic          busy,
   input  logic [NB-1:0] btn_raw,
   output logic          btn_active,
   output logic          sample_ind
);
   initial begin
      if (NB < 1 || NB > 32) $error("hsk_xfer_ctrl: NB must be 1..32");
   end

   logic [NB-1:0] btn_level;
   logic [NB-1:0] btn_rel;

   hsk_xfer_seq #(.DW(DW)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .dir_sel    (dir_sel),
      .start_stb  (start_stb),
      .host_req   (host_req),
      .host_wdata (host_wdata),
      .local_valid(local_valid),
      .local_data (local_data),
      .xfer_done  (xfer_done),
      .ready_n    (ready_n),
      .host_rdata (host_rdata),
      .tty_data   (tty_data),
      .tty_load   (tty_load),
      .busy       (busy)
   );

   generate
      for (genvar gi = 0; gi < NB; gi++) begin : g_btn
         hsk_btn_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .DEB_CYCLES (DEB_CYCLES)
         ) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_in   (btn_raw[gi]),
            .level_out(btn_level[gi]),
            .release_p(btn_rel[gi])
         );
      end
   endgenerate

   assign btn_active = |btn_level;

   hsk_sample_stretch #(
      .NB        (NB),
      .IND_CYCLES(IND_CYCLES),
      .RETRIGGER (RETRIGGER)
   ) u_stretch (
      .clk        (clk),
      .rst_n      (rst_n),
      .release_vec(btn_rel),
      .ind_out    (sample_ind)
   );
endmodule

// File: rtl/hsk_xfer_ctrl_chk.sv
module hsk_xfer_ctrl_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          host_req,
   input logic          ready_n,
   input logic [DW-1:0] host_rdata,
   input logic          tty_load,
   input logic          xfer_done,
   input logic          busy
);
   a_r1_idle_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> ready_n);

   a_r3_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready_n) |-> ($past(host_req) && $past(busy)));

   a_r3_rdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready_n && $past(!ready_n)) |-> $stable(host_rdata));

   a_r5_release_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready_n && !host_req && !xfer_done) |=> ready_n);

   a_r6_load_at_handoff: assert property (@(posedge clk) disable iff (!rst_n)
      tty_load |-> ($past(!ready_n) && ready_n));

   a_r7_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> (!busy && ready_n));
endmodule

bind hsk_xfer_ctrl hsk_xfer_ctrl_chk #(.DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .host_req  (host_req),
   .ready_n   (ready_n),
   .host_rdata(host_rdata),
   .tty_load  (tty_load),
   .xfer_done (xfer_done),
   .busy      (busy)
);

// File: tb/hsk_xfer_ctrl_tb.sv
`timescale 1ns/1ps
module hsk_xfer_ctrl_tb;
   localparam int DW  = 8;
   localparam int NB  = 4;
   localparam int DEB = 8;
   localparam int IND = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dir_sel = 1'b0, start_stb = 1'b0, host_req = 1'b0;
   logic [DW-1:0] host_wdata = '0, local_data = '0;
   logic          local_valid = 1'b0, xfer_done = 1'b0;
   logic [NB-1:0] btn_raw = '0;
   logic          ready_n, tty_load, busy, btn_active, sample_ind;
   logic [DW-1:0] host_rdata, tty_data;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   hsk_xfer_ctrl #(.DW(DW), .NB(NB), .SYNC_STAGES(2), .DEB_CYCLES(DEB),
                   .IND_CYCLES(IND), .RETRIGGER(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .dir_sel(dir_sel), .start_stb(start_stb),
      .host_req(host_req), .host_wdata(host_wdata), .ready_n(ready_n),
      .host_rdata(host_rdata), .local_valid(local_valid), .local_data(local_data),
      .tty_data(tty_data), .tty_load(tty_load), .xfer_done(xfer_done),
      .busy(busy), .btn_raw(btn_raw), .btn_active(btn_active),
      .sample_ind(sample_ind));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic t_reset();
      chk(ready_n == 1'b1, "R1 ready_n", ready_n, 1);
      chk(busy == 1'b0, "R1 busy", busy, 0);
      chk(tty_load == 1'b0, "R1 tty_load", tty_load, 0);
      chk(btn_active == 1'b0 && sample_ind == 1'b0, "R1 buttons", sample_ind, 0);
   endtask

   task automatic t_input_mode();
      dir_sel = 1'b1; start_stb = 1'b1; step();
      start_stb = 1'b0;
      chk(busy == 1'b1, "R2 busy after strobe", busy, 1);
      host_req = 1'b1; step();
      chk(ready_n == 1'b1, "R3 no word held", ready_n, 1);
      local_valid = 1'b1; local_data = 8'hA5; step();
      local_valid = 1'b0; step();
      chk(ready_n == 1'b0, "R3 ready low", ready_n, 0);
      chk(host_rdata == 8'hA5, "R3 rdata", host_rdata, 8'hA5);
      local_valid = 1'b1; local_data = 8'h3C; step();
      local_valid = 1'b0; step();
      chk(host_rdata == 8'hA5, "R4 offer while held ignored", host_rdata, 8'hA5);
      host_req = 1'b0; step();
      chk(ready_n == 1'b1, "R5 ready high after drop", ready_n, 1);
      host_req = 1'b1; step(3);
      chk(ready_n == 1'b1, "R5 stays high without word", ready_n, 1);
      local_valid = 1'b1; local_data = 8'h3C; step();
      local_valid = 1'b0; step();
      chk(ready_n == 1'b0 && host_rdata == 8'h3C, "R4 second word", host_rdata, 8'h3C);
      xfer_done = 1'b1; step();
      xfer_done = 1'b0; host_req = 1'b0;
      chk(busy == 1'b0 && ready_n == 1'b1, "R7 done during ready", busy, 0);
   endtask

   task automatic t_output_mode();
      int loads;
      dir_sel = 1'b0; start_stb = 1'b1; step();
      start_stb = 1'b0; dir_sel = 1'b1;
      host_req = 1'b1; step();
      chk(ready_n == 1'b0, "R6 ready low on req", ready_n, 0);
      start_stb = 1'b1; step();
      start_stb = 1'b0;
      chk(ready_n == 1'b0 && busy == 1'b1, "R2 strobe while busy ignored", ready_n, 0);
      host_wdata = 8'h41; host_req = 1'b0; step();
      chk(ready_n == 1'b1, "R6 ready high at handoff", ready_n, 1);
      chk(tty_load == 1'b1 && tty_data == 8'h41, "R6 tty capture (R2 dir kept)", tty_data, 8'h41);
      host_wdata = 8'h00; step();
      chk(tty_load == 1'b0, "R6 load one cycle", tty_load, 0);
      loads = 0;
      host_req = 1'b1; step();
      host_wdata = 8'h5A; host_req = 1'b0; step();
      if (tty_load) loads++;
      step();
      if (tty_load) loads++;
      chk(loads == 1 && tty_data == 8'h5A, "R6 second word", tty_data, 8'h5A);
      xfer_done = 1'b1; host_req = 1'b1; step();
      xfer_done = 1'b0;
      chk(busy == 1'b0 && ready_n == 1'b1, "R7 done priority", busy, 0);
      host_req = 1'b0; step();
      chk(ready_n == 1'b1, "R7 idle stays ready high", ready_n, 1);
   endtask

   task automatic t_buttons();
      int hi;
      btn_raw[0] = 1'b1; step(3);
      btn_raw[0] = 1'b0; step(DEB + 20);
      chk(btn_active == 1'b0 && sample_ind == 1'b0, "R8 glitch ignored", btn_active, 0);
      btn_raw[0] = 1'b1; step(DEB + 10);
      chk(btn_active == 1'b1, "R8 press accepted", btn_active, 1);
      btn_raw[0] = 1'b0;
      hi = 0;
      for (int i = 0; i < IND + 40; i++) begin
         step();
         if (sample_ind) hi++;
      end
      chk(btn_active == 1'b0, "R8 release accepted", btn_active, 0);
      chk(hi == IND, "R9 indicator width", hi, IND);
      btn_raw[1] = 1'b1; btn_raw[2] = 1'b1; step(DEB + 10);
      btn_raw[1] = 1'b0; step(5);
      btn_raw[2] = 1'b0;
      hi = 0;
      for (int i = 0; i < IND + 50; i++) begin
         step();
         if (sample_ind) hi++;
      end
      chk(hi == IND + 5, "R10 retrigger width", hi, IND + 5);
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step();
      t_reset();
      t_input_mode();
      step(2);
      t_output_mode();
      step(2);
      t_buttons();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule